// File: doc/BRIEF.md
# Power-Management Event Block with APM Command Port

This block gathers the fixed power-management event registers and a small APM command and status pair behind one register bus. It keeps sticky status flags for a real-time-clock alarm, a power-button press, a global-release request and a PM timer overflow. It also keeps an enable word, a 16-bit control word and a free-running PM timer. The timer advances once per `tick_i`. In a system, `tick_i` is a one-cycle strobe at 3 579 545 Hz. The system interrupt `sci_o` is a level signal. It stays high while any of the four event flags is pending with its enable bit set.

Firmware hands power management to the operating system through the APM command byte. Writing code 0xF1 there sets the SCI-enable bit of the control word. Writing code 0xF0 clears it. Any write to the command byte also raises a single-cycle `smi_o` request when the system-management enable input is high.

Reads are combinational. `rdata_o` follows the address, space select and `req_i` in the same cycle. Writes take effect at the next rising clock edge.

Top module: `acpi_pm_apm`

## Requirements
- R1: After reset, every register reads zero and both `sci_o` and `smi_o` are low.
- R2: PM-space accesses must be word aligned (addr[1:0]=0). Other addresses neither read nor write.
  - Word 0 holds status in bits [15:0] and enable in bits [31:16].
  - Word 4 holds control in bits [15:0].
  - Word 8 holds the timer, zero-extended.
  - Word 12 reads zero.
  - Each byte lane is written only when its `be_i` bit is set.
- R3: A strobe on `rtc_evt_i`, `pwrbtn_evt_i` or `gbl_evt_i` sets status bit 10, bit 8 or bit 5 respectively, whatever the enable bits hold. All other status bits, except bit 0, always read zero.
- R4: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. When an event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: `sci_o` is high exactly when status AND enable has any of bits 0, 5, 8 or 10 set. Enable bit 13 (suspend enable) and all other enable bits are stored and read back, but they never drive `sci_o`.
- R6: The timer is `TMR_W` bits wide (24 by default). It increments once per cycle with `tick_i` high and wraps to zero. Bus writes do not affect it.
- R7: When the timer wraps from all ones to zero, status bit 0 is set only if enable bit 0 was set in that cycle.
- R8: APM-space accesses decode only when addr[3:1]=0. addr[0]=0 selects the command byte and addr[0]=1 selects the status byte. Data travels in bits [7:0] of the bus, each byte reads back its last written value, and `be_i` is ignored in this space.
- R9: A command write of 0xF1 sets control bit 0 and a command write of 0xF0 clears it. Any other command value leaves the control word alone. Writes to the APM status byte never touch the control word.
- R10: `smi_o` is high for the one cycle after each command-byte write made while `smi_en_i` is high. It never rises for a status-byte write or while `smi_en_i` is low.
- R11: All 16 control bits are readable and writable by byte lane through word 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| apm_sel_i | input | 1 | 0 = PM register space, 1 = APM port space |
| addr_i | input | 4 | Byte offset within the selected space |
| be_i | input | 4 | Byte-lane enables for PM space |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| rtc_evt_i | input | 1 | RTC alarm event strobe |
| pwrbtn_evt_i | input | 1 | Power-button event strobe |
| gbl_evt_i | input | 1 | Global-release event strobe |
| tick_i | input | 1 | PM timer count enable |
| smi_en_i | input | 1 | System-management interrupt enable |
| sci_o | output | 1 | Level system control interrupt |
| smi_o | output | 1 | One-cycle SMI request |

## Verification
The SCI logic is driven in three ways:
- with pending events under enables that do not match, to show that status is captured independently of the enables;
- with enables matching one event at a time;
- with only the suspend enable set, to show that bit 13 is inert.

Clears are tried as a one-bit write, as an all-zero write and as a write that coincides with an event, which separates write-one-to-clear from plain store and shows that set wins over clear. The APM port is driven with both magic codes, a neutral code and status writes, each with `smi_en_i` high and low. A long tick run crosses the wrap point once with the overflow enable clear and once with it set. Random bus traffic with byte masks and misaligned addresses then runs against a model built from the requirements.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;
  localparam int STS_TMR    = 0;
  localparam int STS_GBL    = 5;
  localparam int STS_PWRBTN = 8;
  localparam int STS_RTC    = 10;
  localparam int EN_SUSP    = 13;
  localparam int CTL_SCIEN  = 0;

  localparam logic [15:0] EVT_MASK = 16'h0521;

  localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hF0;

  typedef enum logic [1:0] {
    W_EVT = 2'd0,
    W_CTL = 2'd1,
    W_TMR = 2'd2,
    W_RSV = 2'd3
  } pm_word_e;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q);

  // R6
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == W'($past(cnt_q) + W'(1)));
  // R6
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import acpi_pm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rtc_i,
  input  logic        pwrbtn_i,
  input  logic        gbl_i,
  input  logic        wrap_i,
  input  logic [15:0] sts_clr_i,
  input  logic [1:0]  en_we_i,
  input  logic [15:0] en_wdata_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic        sci_o
);
  logic [15:0] sts_q, en_q, set_v;

  always_comb begin
    set_v             = '0;
    set_v[STS_TMR]    = wrap_i & en_q[STS_TMR];
    set_v[STS_GBL]    = gbl_i;
    set_v[STS_PWRBTN] = pwrbtn_i;
    set_v[STS_RTC]    = rtc_i;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_q & ~sts_clr_i) | set_v) & EVT_MASK;
  end

  for (genvar b = 0; b < 2; b++) begin : g_en_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         en_q[8*b +: 8] <= '0;
      else if (en_we_i[b]) en_q[8*b +: 8] <= en_wdata_i[8*b +: 8];
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = |(sts_q & en_q & EVT_MASK);

  // R3
  rtc_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[STS_RTC]) |-> $past(rtc_i));
  // R7
  tmr_ovf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[STS_TMR]) |-> $past(wrap_i && en_q[STS_TMR]));
  // R4
  pwrbtn_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i[STS_PWRBTN] && !pwrbtn_i) |=> !sts_q[STS_PWRBTN]);
  // R5
  sci_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_o) |-> (|($past(set_v)) || $past(en_we_i) != 2'b00));
endmodule

// File: rtl/apm_ports.sv
module apm_ports
  import acpi_pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  input  logic       smi_en_i,
  output logic [7:0] cmd_o,
  output logic [7:0] stat_o,
  output logic       sci_on_o,
  output logic       sci_off_o,
  output logic       smi_o
);
  logic [7:0] cmd_q, stat_q;
  logic       smi_q, cmd_we;

  assign cmd_we = we_i & ~sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
      smi_q  <= 1'b0;
    end else begin
      if (cmd_we)        cmd_q  <= wdata_i;
      if (we_i && sel_i) stat_q <= wdata_i;
      smi_q <= cmd_we & smi_en_i;
    end
  end

  assign cmd_o     = cmd_q;
  assign stat_o    = stat_q;
  assign smi_o     = smi_q;
  assign sci_on_o  = cmd_we && (wdata_i == APM_ACPI_ON);
  assign sci_off_o = cmd_we && (wdata_i == APM_ACPI_OFF);

  // R10
  smi_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(we_i && !sel_i && smi_en_i));
  // R10
  smi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_en_i |=> !smi_o);
endmodule

// File: rtl/acpi_pm_apm.sv
module acpi_pm_apm
  import acpi_pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        apm_sel_i,
  input  logic [3:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rtc_evt_i,
  input  logic        pwrbtn_evt_i,
  input  logic        gbl_evt_i,
  input  logic        tick_i,
  input  logic        smi_en_i,
  output logic        sci_o,
  output logic        smi_o
);
  localparam int RD_PAD = 32 - TMR_W;

  logic             pm_hit, apm_hit, pm_wr, apm_wr;
  pm_word_e         word;
  logic [15:0]      sts, en, ctl_q, sts_clr, lane_mask;
  logic [1:0]       en_we;
  logic [TMR_W-1:0] tmr;
  logic             wrap, sci_on, sci_off;
  logic [7:0]       apm_cmd, apm_stat;

  assign pm_hit  = req_i & ~apm_sel_i & (addr_i[1:0] == 2'b00);
  assign apm_hit = req_i & apm_sel_i & (addr_i[3:1] == 3'b000);
  assign pm_wr   = pm_hit & we_i;
  assign apm_wr  = apm_hit & we_i;
  assign word    = pm_word_e'(addr_i[3:2]);

  assign lane_mask = {{8{be_i[1]}}, {8{be_i[0]}}};
  assign sts_clr   = (pm_wr && word == W_EVT) ? (wdata_i[15:0] & lane_mask) : '0;
  assign en_we     = (pm_wr && word == W_EVT) ? be_i[3:2] : 2'b00;

  pm_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (tmr),
    .wrap_o (wrap)
  );

  pm_evt_regs u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rtc_i      (rtc_evt_i),
    .pwrbtn_i   (pwrbtn_evt_i),
    .gbl_i      (gbl_evt_i),
    .wrap_i     (wrap),
    .sts_clr_i  (sts_clr),
    .en_we_i    (en_we),
    .en_wdata_i (wdata_i[31:16]),
    .sts_o      (sts),
    .en_o       (en),
    .sci_o      (sci_o)
  );

  apm_ports u_apm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (apm_wr),
    .sel_i     (addr_i[0]),
    .wdata_i   (wdata_i[7:0]),
    .smi_en_i  (smi_en_i),
    .cmd_o     (apm_cmd),
    .stat_o    (apm_stat),
    .sci_on_o  (sci_on),
    .sci_off_o (sci_off),
    .smi_o     (smi_o)
  );

  // control word; APM magic codes override bit 0 (spaces never collide)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (pm_wr && word == W_CTL) begin
        if (be_i[0]) ctl_q[7:0]  <= wdata_i[7:0];
        if (be_i[1]) ctl_q[15:8] <= wdata_i[15:8];
      end
      if (sci_on)       ctl_q[CTL_SCIEN] <= 1'b1;
      else if (sci_off) ctl_q[CTL_SCIEN] <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (apm_hit) begin
      rdata_o[7:0] = addr_i[0] ? apm_stat : apm_cmd;
    end else if (pm_hit) begin
      unique case (word)
        W_EVT:   rdata_o = {en, sts};
        W_CTL:   rdata_o = {16'h0, ctl_q};
        W_TMR:   rdata_o = {{RD_PAD{1'b0}}, tmr};
        default: rdata_o = '0;
      endcase
    end
  end

  // R9
  apm_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_wr && !addr_i[0] && wdata_i[7:0] == APM_ACPI_ON) |=> ctl_q[CTL_SCIEN]);
  // R9
  apm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_wr && !addr_i[0] && wdata_i[7:0] == APM_ACPI_OFF) |=> !ctl_q[CTL_SCIEN]);
  // R2
  ctl_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(pm_wr && word == W_CTL) && !apm_wr) |=> $stable(ctl_q));
endmodule

// File: tb/acpi_pm_apm_tb_top.sv
module acpi_pm_apm_tb_top;
  localparam int TW = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, apm_sel = 0;
  logic [3:0]  addr = 0, be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        rtc = 0, pwr = 0, gbl = 0, tick = 0, smi_en = 0;
  logic        sci, smi;

  int checks = 0, errors = 0;

  logic [15:0]   m_sts = 0, m_en = 0, m_ctl = 0;
  logic [TW-1:0] m_tmr = 0;
  logic [7:0]    m_cmd = 0, m_stat = 0;
  logic          m_smi = 0;

  always #4 clk = ~clk;

  acpi_pm_apm #(.TMR_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .apm_sel_i(apm_sel),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .rtc_evt_i(rtc), .pwrbtn_evt_i(pwr), .gbl_evt_i(gbl), .tick_i(tick),
    .smi_en_i(smi_en), .sci_o(sci), .smi_o(smi)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic sp, logic [3:0] a);
    if (sp) return (a[3:1] == 3'b0) ? {24'h0, (a[0] ? m_stat : m_cmd)} : 32'h0;
    if (a[1:0] != 2'b0) return 32'h0;
    case (a[3:2])
      2'd0:    return {m_en, m_sts};
      2'd1:    return {16'h0, m_ctl};
      2'd2:    return 32'(m_tmr);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_sci();
    return |(m_sts & m_en & 16'h0521);
  endfunction

  // inputs already set at a negedge; model, clock once, check outputs
  task automatic cycle(string tag);
    logic [15:0] clr, setv, nen, nctl;
    logic pmw, apw;
    pmw = req && we && !apm_sel && addr[1:0] == 2'b0;
    apw = req && we && apm_sel && addr[3:1] == 3'b0;
    clr = 0; setv = 0; nen = m_en; nctl = m_ctl;
    setv[0]  = tick && (m_tmr == '1) && m_en[0];
    setv[5]  = gbl; setv[8] = pwr; setv[10] = rtc;
    if (pmw && addr[3:2] == 2'd0) begin
      if (be[0]) clr[7:0]  = wdata[7:0];
      if (be[1]) clr[15:8] = wdata[15:8];
      if (be[2]) nen[7:0]  = wdata[23:16];
      if (be[3]) nen[15:8] = wdata[31:24];
    end
    if (pmw && addr[3:2] == 2'd1) begin
      if (be[0]) nctl[7:0]  = wdata[7:0];
      if (be[1]) nctl[15:8] = wdata[15:8];
    end
    m_smi = 0;
    if (apw) begin
      if (addr[0]) m_stat = wdata[7:0];
      else begin
        m_cmd = wdata[7:0];
        if (wdata[7:0] == 8'hF1) nctl[0] = 1'b1;
        else if (wdata[7:0] == 8'hF0) nctl[0] = 1'b0;
        m_smi = smi_en;
      end
    end
    m_sts = ((m_sts & ~clr) | setv) & 16'h0521;
    m_en = nen; m_ctl = nctl;
    if (tick) m_tmr = m_tmr + 1'b1;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0; rtc = 0; pwr = 0; gbl = 0; tick = 0;
    chk({tag, " R5 sci"}, 32'(sci), 32'(exp_sci()));
    chk({tag, " R10 smi"}, 32'(smi), 32'(m_smi));
  endtask

  task automatic rd(logic sp, logic [3:0] a, string tag);
    req = 1; we = 0; apm_sel = sp; addr = a; #1;
    chk(tag, rdata, exp_rd(sp, a));
    req = 0;
  endtask

  task automatic wr(logic sp, logic [3:0] a, logic [3:0] b, logic [31:0] d);
    req = 1; we = 1; apm_sel = sp; addr = a; be = b; wdata = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sci", 32'(sci), 0); chk("R1 smi", 32'(smi), 0);
    rd(0, 4'd0, "R1 evt"); rd(0, 4'd4, "R1 ctl"); rd(1, 4'd0, "R1 cmd"); rd(1, 4'd1, "R1 stat");
    rst_n = 1; @(negedge clk);
    rd(0, 4'd8, "R1 tmr");

    // R3 events latch with enables clear, no SCI
    rtc = 1; pwr = 1; gbl = 1; cycle("R3 ev");
    rd(0, 4'd0, "R3 sts");
    // R5 suspend enable only: no SCI
    wr(0, 4'd0, 4'b1100, 32'h2000_0000); cycle("R5 susp");
    rd(0, 4'd0, "R5 en13");
    // R2 byte lane: enable low byte only (bit 5)
    wr(0, 4'd0, 4'b0100, 32'hFFFF_0020); cycle("R2 lane");
    rd(0, 4'd0, "R2 lane rd");
    // R4 clear gbl, write zeros, clear vs event race on pwr
    wr(0, 4'd0, 4'b0001, 32'h0000_0020); cycle("R4 clr");
    rd(0, 4'd0, "R4 clr rd");
    wr(0, 4'd0, 4'b0011, 32'h0); cycle("R4 zero");
    rd(0, 4'd0, "R4 zero rd");
    wr(0, 4'd0, 4'b0010, 32'h0000_0100); pwr = 1; cycle("R4 race");
    rd(0, 4'd0, "R4 race rd");
    // R2 misaligned write ignored
    wr(0, 4'd1, 4'b1111, 32'hFFFF_FFFF); cycle("R2 misalign");
    rd(0, 4'd0, "R2 misalign rd"); rd(0, 4'd1, "R2 misalign rd0");
    // R5 enable rtc -> SCI
    wr(0, 4'd0, 4'b1100, 32'h0400_0000); cycle("R5 rtc en");
    // R11 control byte lanes
    wr(0, 4'd4, 4'b0011, 32'h0000_A5C3); cycle("R11 ctl");
    rd(0, 4'd4, "R11 ctl rd");
    wr(0, 4'd4, 4'b0010, 32'h0000_1200); cycle("R11 ctl hi");
    rd(0, 4'd4, "R11 ctl hi rd");
    // R9/R10 APM
    smi_en = 0;
    wr(1, 4'd0, 4'b0000, 32'hF0); cycle("R9 off nosmi");
    rd(0, 4'd4, "R9 off rd"); rd(1, 4'd0, "R8 cmd rd");
    smi_en = 1;
    wr(1, 4'd0, 4'b0000, 32'hF1); cycle("R9 on smi");
    rd(0, 4'd4, "R9 on rd");
    wr(1, 4'd0, 4'b0000, 32'h5A); cycle("R9 neutral");
    rd(0, 4'd4, "R9 neutral rd");
    wr(1, 4'd1, 4'b0000, 32'hF0); cycle("R10 stat nosmi");
    rd(1, 4'd1, "R8 stat rd"); rd(0, 4'd4, "R9 stat noeff");
    wr(1, 4'd2, 4'b0000, 32'h77); cycle("R8 bad addr");
    rd(1, 4'd0, "R8 bad rd"); rd(1, 4'd2, "R8 bad rd2");
    // R6 timer read-only
    wr(0, 4'd8, 4'b1111, 32'h0000_03FF); tick = 1; cycle("R6 ro");
    rd(0, 4'd8, "R6 ro rd");
    // R7 wrap with overflow enable clear
    for (int i = 0; i < (1 << TW); i++) begin tick = 1; cycle("R7 run0"); end
    rd(0, 4'd0, "R7 noen rd"); rd(0, 4'd8, "R6 wrap rd");
    wr(0, 4'd0, 4'b0100, 32'h0001_0000); cycle("R7 en");
    for (int i = 0; i < (1 << TW); i++) begin tick = 1; cycle("R7 run1"); end
    rd(0, 4'd0, "R7 en rd");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      smi_en = 1'($urandom);
      case (k)
        0, 1: wr(0, 4'd0, 4'($urandom), $urandom);
        2:    wr(0, 4'd4, 4'($urandom), $urandom);
        3:    wr(0, 4'($urandom), 4'($urandom), $urandom);
        4:    wr(1, 4'd0, 4'b0, {24'h0, ($urandom_range(0, 1) != 0) ? 8'hF0 + 8'($urandom_range(0, 1)) : 8'($urandom)});
        5:    wr(1, 4'($urandom), 4'b0, $urandom);
        default: ;
      endcase
      rtc = ($urandom_range(0, 7) == 0); pwr = ($urandom_range(0, 7) == 0);
      gbl = ($urandom_range(0, 7) == 0); tick = 1'($urandom);
      cycle("RND");
      if (n % 2 == 0) rd(0, 4'($urandom), "R2 rnd rd");
      else            rd(1, 4'($urandom), "R8 rnd rd");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule